// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small word-addressed memory and performs memory operations on it, one at a time, from a single request port. Each request names an operation, a word address and up to two operands. The block answers with a response that carries the word it found, a success flag for compare-and-swap and an error flag for codes it does not know. Software lock primitives map onto it directly: spin locks use test-and-set, counters and tickets use fetch-and-add, and lock-free updates use compare-and-swap.

Every operation runs in two fixed clock cycles. In the first cycle the addressed word is read. In the second cycle the new value is conditionally written back, and the port refuses new work during that cycle. The read and the write therefore form one indivisible step, because no other access can reach the memory between them.

Top module: `rmw_atomic_unit`

## Requirements
- R1: After synchronous reset, every memory word reads as zero, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 during the cycle after that edge. `rsp_valid` is 1 for exactly one cycle, which is the cycle after the second edge following acceptance.
- R3: Opcode 0 (load) returns the addressed word in `rsp_data` and leaves memory unchanged.
- R4: Opcode 1 (store) writes operand A to the word and returns 0 in `rsp_data`.
- R5: Opcode 2 (test-and-set) returns the old word. It writes 1 only when the old word was 0, and otherwise leaves the word unchanged.
- R6: Opcode 3 (fetch-and-add) returns the old word and writes old plus operand A, wrapping modulo 2^W.
- R7: Opcode 4 (swap) writes operand A and returns the previous contents.
- R8: Opcode 5 (compare-and-swap) compares the word with operand A. If they are equal it writes operand B and sets `rsp_status` to 1. If not, memory is unchanged and `rsp_status` is 0. In both cases `rsp_data` is the word observed before the operation.
- R9: Opcodes 6 and 7 give `rsp_err` = 1, `rsp_data` = 0 and `rsp_status` = 0, and they leave memory untouched.
- R10: For opcodes 0 to 4, `rsp_status` is 0 and `rsp_err` is 0. `rsp_status` and `rsp_err` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | AW | Word address |
| req_opa | input | W | Operand A: store/swap value, add amount, compare value |
| req_opb | input | W | Operand B: compare-and-swap new value |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_data | output | W | Word observed before the operation (0 for store and error) |
| rsp_status | output | 1 | Compare-and-swap succeeded |
| rsp_err | output | 1 | Unknown opcode |

## Verification
The bench goes after the conditional writes:
- Test-and-set is driven on both zero and non-zero words. A design that writes unconditionally would turn a held lock value such as 5 into 1.
- Compare-and-swap is driven with matching and mismatching expected values. A design that wrote on failure, or returned operand B instead of the observed word, would be caught by the loads that follow.
- Fetch-and-add is pushed across the all-ones boundary, so that missing wrap-around shows up.
- Unknown opcodes are followed by loads of the same word to prove that nothing was written.

A random mix over a few addresses keeps a model memory in step with the design, so any stray write surfaces on a later access.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_TAS   = 3'd2,
        OP_FAA   = 3'd3,
        OP_SWAP  = 3'd4,
        OP_CAS   = 3'd5
    } rmw_op_e;

    // control outcome of one operation
    typedef struct packed {
        logic wr;        // write back the new value
        logic ok;        // compare-and-swap matched
        logic err;       // opcode not recognised
        logic zero_data; // response carries 0 instead of the old word
    } rmw_ctl_t;

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

endpackage

// File: rtl/rmw_mem.sv
module rmw_mem #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);
    logic [W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= '0;
            else if (wr_en && wr_addr == AW'(g))
                words[g] <= wr_data;
        end
    end

    assign rd_data = words[rd_addr];
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] new_val,
    output rmw_ctl_t     ctl
);
    always_comb begin
        new_val = old_val;
        ctl     = '{wr: 1'b0, ok: 1'b0, err: 1'b0, zero_data: 1'b0};
        if (!op_known(op)) begin
            ctl.err       = 1'b1;
            ctl.zero_data = 1'b1;
        end else begin
            unique case (rmw_op_e'(op))
                OP_LOAD: ;
                OP_STORE: begin
                    new_val       = opa;
                    ctl.wr        = 1'b1;
                    ctl.zero_data = 1'b1;
                end
                OP_TAS: begin
                    new_val = W'(1);
                    ctl.wr  = (old_val == '0);
                end
                OP_FAA: begin
                    new_val = old_val + opa;
                    ctl.wr  = 1'b1;
                end
                OP_SWAP: begin
                    new_val = opa;
                    ctl.wr  = 1'b1;
                end
                OP_CAS: begin
                    new_val = opb;
                    ctl.ok  = (old_val == opa);
                    ctl.wr  = (old_val == opa);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    output logic req_ready,
    output logic accept,
    output logic in_write
);
    typedef enum logic {ST_IDLE, ST_WRITE} st_e;
    st_e st;

    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign in_write  = (st == ST_WRITE);

    always_ff @(posedge clk) begin
        if (rst)
            st <= ST_IDLE;
        else if (accept)
            st <= ST_WRITE;
        else
            st <= ST_IDLE;
    end

    // R2: no second acceptance in the cycle after one
    p_no_back_to_back_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);
endmodule

// File: rtl/rmw_atomic_unit.sv
module rmw_atomic_unit
    import rmw_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [W-1:0]  req_opa,
    input  logic [W-1:0]  req_opb,
    output logic          rsp_valid,
    output logic [W-1:0]  rsp_data,
    output logic          rsp_status,
    output logic          rsp_err
);
    logic          accept, in_write;
    logic [2:0]    op_q;
    logic [AW-1:0] addr_q;
    logic [W-1:0]  opa_q, opb_q, old_q, rd_data, new_val;
    rmw_ctl_t      ctl;
    logic          wr_en;

    rmw_seq u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .req_ready(req_ready), .accept(accept), .in_write(in_write)
    );

    rmw_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst(rst), .rd_addr(req_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(addr_q), .wr_data(new_val)
    );

    rmw_alu #(.W(W)) u_alu (
        .op(op_q), .old_val(old_q), .opa(opa_q), .opb(opb_q),
        .new_val(new_val), .ctl(ctl)
    );

    assign wr_en = in_write && ctl.wr;

    // read cycle: capture the request and the addressed word
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            addr_q <= '0;
            opa_q  <= '0;
            opb_q  <= '0;
            old_q  <= '0;
        end else if (accept) begin
            op_q   <= req_op;
            addr_q <= req_addr;
            opa_q  <= req_opa;
            opb_q  <= req_opb;
            old_q  <= rd_data;
        end
    end

    // write cycle: commit and register the response
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            rsp_status <= 1'b0;
            rsp_err    <= 1'b0;
        end else begin
            rsp_valid <= in_write;
            if (in_write) begin
                rsp_data   <= ctl.zero_data ? '0 : old_q;
                rsp_status <= ctl.ok;
                rsp_err    <= ctl.err;
            end
        end
    end

    // R2: response follows acceptance after two edges, for one cycle
    p_rsp_latency_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> ##1 rsp_valid);
    p_rsp_single_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    // R5: test-and-set commits only onto a zero word, and commits 1
    p_tas_on_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_q == OP_TAS) |-> (old_q == '0 && new_val == W'(1)));
    // R8 / R9: failed compare-and-swap and errors leave memory alone
    p_no_write_on_fail_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_err || ($past(op_q) == OP_CAS && !rsp_status)))
            |-> !$past(wr_en));
    // R10: status and error never together
    p_status_err_excl_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_status && rsp_err));
endmodule

// File: tb/sim_rmw_atomic_unit.sv
module sim_rmw_atomic_unit;
    localparam int W = 32;
    localparam int DEPTH = 16;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [W-1:0] req_opa = '0, req_opb = '0;
    logic rsp_valid, rsp_status, rsp_err;
    logic [W-1:0] rsp_data;

    int n_run = 0, n_fail = 0;
    logic [W-1:0] mdl [DEPTH];

    always #10 clk = ~clk; // 50 MHz

    rmw_atomic_unit #(.W(W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_status(rsp_status),
        .rsp_err(rsp_err)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] op, input int addr,
                          input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] old, nv, exp_data;
        bit wr, exp_st, exp_err;
        string t;
        t = tag_of(op);
        old = mdl[addr];
        nv = old; wr = 0; exp_st = 0; exp_err = 0; exp_data = old;
        case (op)
            3'd0: ;
            3'd1: begin nv = a; wr = 1; exp_data = '0; end
            3'd2: begin nv = 1; wr = (old == 0); end
            3'd3: begin nv = old + a; wr = 1; end
            3'd4: begin nv = a; wr = 1; end
            3'd5: begin nv = b; wr = (old == a); exp_st = (old == a); end
            default: begin exp_err = 1; exp_data = '0; end
        endcase
        @(negedge clk);
        chk(rsp_valid == 0, "R2 idle rsp_valid", W'(rsp_valid), 0);
        chk(req_ready == 1, "R2 ready before", W'(req_ready), 1);
        req_valid = 1; req_op = op; req_addr = AW'(addr); req_opa = a; req_opb = b;
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 0, "R2 ready low in write", W'(req_ready), 0);
        chk(rsp_valid == 0, "R2 no early rsp", W'(rsp_valid), 0);
        @(negedge clk);
        chk(rsp_valid == 1, "R2 rsp_valid", W'(rsp_valid), 1);
        chk(rsp_data == exp_data, {t, " rsp_data"}, rsp_data, exp_data);
        chk(rsp_status == exp_st, {t, " R10 rsp_status"}, W'(rsp_status), W'(exp_st));
        chk(rsp_err == exp_err, {t, " R10 rsp_err"}, W'(rsp_err), W'(exp_err));
        if (wr) mdl[addr] = nv;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(req_ready == 1, "R1 ready after reset", W'(req_ready), 1);
        chk(rsp_valid == 0, "R1 rsp_valid after reset", W'(rsp_valid), 0);
        // R1: every word reads zero
        for (int i = 0; i < DEPTH; i++) run_op(3'd0, i, 0, 0);

        // directed corner cases
        run_op(3'd2, 3, 0, 0);            // R5 on zero: writes 1
        run_op(3'd2, 3, 0, 0);            // R5 on 1: no write
        run_op(3'd1, 4, 32'd5, 0);        // R4 store 5
        run_op(3'd2, 4, 0, 0);            // R5 on 5: stays 5
        run_op(3'd0, 4, 0, 0);
        run_op(3'd1, 5, 32'hFFFF_FFFE, 0);
        run_op(3'd3, 5, 32'd3, 0);        // R6 wraps to 1
        run_op(3'd0, 5, 0, 0);
        run_op(3'd5, 5, 32'd9, 32'd77);   // R8 fail
        run_op(3'd0, 5, 0, 0);
        run_op(3'd5, 5, 32'd1, 32'd77);   // R8 success
        run_op(3'd0, 5, 0, 0);
        run_op(3'd4, 6, 32'hA5A5_0001, 0);// R7
        run_op(3'd0, 6, 0, 0);
        run_op(3'd6, 6, 32'h1, 32'h2);    // R9
        run_op(3'd7, 6, 32'h3, 32'h4);    // R9
        run_op(3'd0, 6, 0, 0);            // R9 memory untouched

        // constrained random mix over a few addresses
        for (int k = 0; k < 1500; k++) begin
            int ad;
            logic [2:0] op;
            logic [W-1:0] a, b;
            ad = int'($urandom_range(0, 5));
            op = 3'($urandom_range(0, 7));
            a = ($urandom_range(0, 3) == 0) ? W'($urandom) : W'($urandom_range(0, 3));
            if (op == 3'd5 && $urandom_range(0, 1) == 1) a = mdl[ad];
            if (op == 3'd1 && $urandom_range(0, 3) == 0) a = 0;
            b = W'($urandom);
            run_op(op, ad, a, b);
        end
        for (int i = 0; i < DEPTH; i++) run_op(3'd0, i, 0, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule